// File: doc/BRIEF.md
# Three-Mode NCO Quadrature Modulator

This block turns baseband data into one real sample stream at the full clock rate. A 32-bit phase accumulator advances by a tuning word on every clock. A phase-to-amplitude stage turns the top accumulator bits into a cosine and a sine carrier. A two-bit mode register selects one of three behaviours. In quadrature mode the block mixes I with the cosine and Q with the sine and adds the two products. In tone mode it sends out the bare cosine carrier. In pass-through mode the I stream goes straight to the output. A final stage multiplies the result by an 8-bit gain in every mode.

Four tuning words are held in registers, and two profile pins choose which one drives the accumulator. The mode, the gain and the four tuning words are loaded through a clocked serial frame. The DAC, the clock multiplier and the interpolation filters lie outside this block.

Top module: `dds_qmod`

## Requirements
- R1: After reset the mode is quadrature (code 0), the gain is 128, all four tuning words are 0, the accumulator is 0 and `dac_o` reads 0.
- R2: While `cfg_sen_i` is high, one bit of `cfg_sdi_i` is shifted in on each clock, MSB first: an 8-bit address and then 32 data bits. The frame takes effect on the first clock with `cfg_sen_i` low. Address 0x00 loads the mode from data[1:0], 0x01 loads the gain from data[7:0], and 0x10 to 0x13 load tuning words 0 to 3.
- R3: A frame of any length other than 40 bits, or a frame with any other address, changes no register.
- R4: On each clock the accumulator adds the tuning word chosen by `prof_sel_i` and wraps modulo 2^32. Its top 10 bits form phase a. With x = a mod 512 and m = floor(x*(512-x)*8191 / 65536), sin(a) = m when a < 512 and -m otherwise; cos(a) = sin((a+256) mod 1024).
- R5: In quadrature mode (code 0, and also the unused code 3), mix = sat(floor((I*cos + Q*sin) / 8192)). The I, Q and phase present before clock edge E appear at `dac_o` after edge E+2.
- R6: In tone mode (code 1), mix = cos and the I and Q inputs have no effect.
- R7: In pass-through mode (code 2), mix = I and Q has no effect.
- R8: `dac_o` = sat(floor(mix*g / 128)) for the 8-bit unsigned gain g, in every mode.
- R9: Both the mixer sum and the gain stage clip to [-8192, 8191] and never wrap.
- R10: A change on `prof_sel_i` selects the new tuning word at the next clock edge. The accumulator phase is kept and is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sen_i | input | 1 | Serial frame enable |
| cfg_sdi_i | input | 1 | Serial frame data, MSB first |
| prof_sel_i | input | 2 | Tuning-word profile select |
| i_data_i | input | 14 | Signed I sample |
| q_data_i | input | 14 | Signed Q sample |
| dac_o | output | 14 | Signed output sample |

## Verification
A wrong accumulator value or a wrong profile choice changes the carrier phase. In tone and quadrature modes this shows at `dac_o` three clocks later and stays wrong for good, because the accumulator never resynchronises. A register loaded from a bad frame, or left unloaded by a good one, changes the mode or the gain from the next sample that reaches the output stage. A clip that wraps instead of saturating shows up as a sign flip on full-scale inputs in the same cycle as the affected sample.

// File: rtl/dds_qmod_pkg.sv
package dds_qmod_pkg;
  localparam int unsigned DATA_W  = 14;
  localparam int unsigned FTW_W   = 32;
  localparam int unsigned SCALE_W = 8;
  localparam int unsigned PROF_N  = 4;
  localparam int unsigned PH_W    = 10;
  localparam int unsigned ADDR_W  = 8;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_TONE = 2'd1,
    MODE_PASS = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_SCALE = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_FTW0  = 8'h10;
endpackage

// File: rtl/dds_cfg_port.sv
module dds_cfg_port
  import dds_qmod_pkg::*;
#(
  parameter int unsigned FTW_W   = dds_qmod_pkg::FTW_W,
  parameter int unsigned SCALE_W = dds_qmod_pkg::SCALE_W,
  parameter int unsigned PROF_N  = dds_qmod_pkg::PROF_N,
  parameter int unsigned ADDR_W  = dds_qmod_pkg::ADDR_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sen_i,
  input  logic                           sdi_i,
  output mode_e                          mode_o,
  output logic [SCALE_W-1:0]             scale_o,
  output logic [PROF_N-1:0][FTW_W-1:0]   ftw_o
);
  localparam int unsigned FRAME_W = ADDR_W + FTW_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [FRAME_W-1:0]           sh_q;
  logic [CNT_W-1:0]             cnt_q;
  mode_e                        mode_q;
  logic [SCALE_W-1:0]           scale_q;
  logic [PROF_N-1:0][FTW_W-1:0] ftw_q;

  logic               frame_ok;
  logic [ADDR_W-1:0]  addr;
  logic [FTW_W-1:0]   data;

  assign frame_ok = !sen_i && (cnt_q == CNT_FULL);
  assign addr     = sh_q[FRAME_W-1 -: ADDR_W];
  assign data     = sh_q[FTW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sen_i) begin
      sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_QUAD;
      scale_q <= SCALE_W'(1 << (SCALE_W - 1));
    end else if (frame_ok) begin
      if (addr == ADDR_MODE)  mode_q  <= mode_e'(data[1:0]);
      if (addr == ADDR_SCALE) scale_q <= data[SCALE_W-1:0];
    end
  end

  for (genvar p = 0; p < int'(PROF_N); p++) begin : g_ftw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ftw_q[p] <= '0;
      else if (frame_ok && addr == ADDR_W'(int'(ADDR_FTW0) + p)) ftw_q[p] <= data;
    end
  end

  assign mode_o  = mode_q;
  assign scale_o = scale_q;
  assign ftw_o   = ftw_q;

  // R3: a frame of the wrong length leaves every register untouched
  p_bad_len_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sen_i && cnt_q != '0 && cnt_q != CNT_FULL)
      |=> ($stable(mode_q) && $stable(scale_q) && $stable(ftw_q)));
endmodule

// File: rtl/dds_nco.sv
module dds_nco #(
  parameter int unsigned FTW_W  = dds_qmod_pkg::FTW_W,
  parameter int unsigned PROF_N = dds_qmod_pkg::PROF_N,
  parameter int unsigned PH_W   = dds_qmod_pkg::PH_W,
  parameter int unsigned DATA_W = dds_qmod_pkg::DATA_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [PROF_N-1:0][FTW_W-1:0]       ftw_i,
  input  logic [$clog2(PROF_N)-1:0]          sel_i,
  output logic signed [DATA_W-1:0]           cos_o,
  output logic signed [DATA_W-1:0]           sin_o
);
  localparam int unsigned HALF_N  = 1 << (PH_W - 1);
  localparam int unsigned QUARTER = 1 << (PH_W - 2);
  localparam int unsigned AMP     = (1 << (DATA_W - 1)) - 1;
  localparam int unsigned SHIFT   = 2 * (PH_W - 1) - 2;
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic [FTW_W-1:0] acc_q;
  logic [FTW_W-1:0] ftw_sel;
  logic [PH_W-1:0]  ph_sin;
  logic [PH_W-1:0]  ph_cos;
  logic signed [DATA_W-1:0] cos_q, sin_q;

  // parabolic half-wave: 4x(N-x)/N^2 scaled to full amplitude
  function automatic logic signed [DATA_W-1:0] amp_of(input logic [PH_W-1:0] a);
    logic [63:0] x64;
    logic [63:0] m64;
    logic signed [DATA_W-1:0] m;
    x64 = 64'(a[PH_W-2:0]);
    m64 = (x64 * (64'(HALF_N) - x64) * 64'(AMP)) >> SHIFT;
    m   = DATA_W'(m64);
    return a[PH_W-1] ? -m : m;
  endfunction

  assign ftw_sel = ftw_i[sel_i];
  assign ph_sin  = acc_q[FTW_W-1 -: PH_W];
  assign ph_cos  = ph_sin + PH_W'(QUARTER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cos_q <= DATA_W'(AMP);
      sin_q <= '0;
    end else begin
      acc_q <= acc_q + ftw_sel;
      cos_q <= amp_of(ph_cos);
      sin_q <= amp_of(ph_sin);
    end
  end

  assign cos_o = cos_q;
  assign sin_o = sin_q;

  // R4: the two carriers are a quarter turn apart, so they never vanish together
  p_lo_quadrature_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cos_q == '0 && sin_q == '0));
  // R4: carrier amplitude stays inside the symmetric range
  p_lo_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_q != MINV) && (sin_q != MINV));
endmodule

// File: rtl/dds_mixer.sv
module dds_mixer
  import dds_qmod_pkg::*;
#(
  parameter int unsigned DATA_W = dds_qmod_pkg::DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  mode_e                    mode_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  input  logic signed [DATA_W-1:0] cos_i,
  input  logic signed [DATA_W-1:0] sin_i,
  output logic signed [DATA_W-1:0] mix_o
);
  localparam int unsigned SUM_W = 2 * DATA_W + 1;
  localparam int unsigned EXT_W = SUM_W - DATA_W + 1;
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] i_q, q_q, mix_q, mix_d;
  logic signed [SUM_W-1:0]  p_i, p_q, sum, sum_sh;

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [SUM_W-1:0] v);
    if (v[SUM_W-1:DATA_W-1] == {EXT_W{v[SUM_W-1]}}) return v[DATA_W-1:0];
    return v[SUM_W-1] ? MINV : MAXV;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q <= '0;
      q_q <= '0;
    end else begin
      i_q <= i_i;
      q_q <= q_i;
    end
  end

  always_comb begin
    p_i    = SUM_W'(i_q) * SUM_W'(cos_i);
    p_q    = SUM_W'(q_q) * SUM_W'(sin_i);
    sum    = p_i + p_q;
    sum_sh = sum >>> (DATA_W - 1);
    unique case (mode_i)
      MODE_TONE: mix_d = cos_i;
      MODE_PASS: mix_d = i_q;
      default:   mix_d = clip(sum_sh);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mix_q <= '0;
    else         mix_q <= mix_d;
  end

  assign mix_o = mix_q;

  // R9: all-positive operands can never produce a negative (wrapped) sum
  p_mix_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_QUAD && !i_q[DATA_W-1] && !q_q[DATA_W-1]
      && !cos_i[DATA_W-1] && !sin_i[DATA_W-1]) |=> !mix_q[DATA_W-1]);
endmodule

// File: rtl/dds_scaler.sv
module dds_scaler #(
  parameter int unsigned DATA_W  = dds_qmod_pkg::DATA_W,
  parameter int unsigned SCALE_W = dds_qmod_pkg::SCALE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] mix_i,
  input  logic [SCALE_W-1:0]       scale_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int unsigned PROD_W = DATA_W + SCALE_W + 1;
  localparam int unsigned EXT_W  = PROD_W - DATA_W + 1;
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod, prod_sh;
  logic signed [DATA_W-1:0] y_q, y_d;

  always_comb begin
    prod    = PROD_W'(mix_i) * $signed({1'b0, scale_i});
    prod_sh = prod >>> (SCALE_W - 1);
    if (prod_sh[PROD_W-1:DATA_W-1] == {EXT_W{prod_sh[PROD_W-1]}})
      y_d = prod_sh[DATA_W-1:0];
    else
      y_d = prod_sh[PROD_W-1] ? MINV : MAXV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= y_d;
  end

  assign y_o = y_q;

  // R9: gain never flips the sign of the sample
  p_scale_pos_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mix_i[DATA_W-1] |=> !y_q[DATA_W-1]);
  p_scale_neg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_i[DATA_W-1] |=> (y_q[DATA_W-1] || y_q == '0));
endmodule

// File: rtl/dds_qmod.sv
module dds_qmod
  import dds_qmod_pkg::*;
#(
  parameter int unsigned DATA_W  = dds_qmod_pkg::DATA_W,
  parameter int unsigned FTW_W   = dds_qmod_pkg::FTW_W,
  parameter int unsigned SCALE_W = dds_qmod_pkg::SCALE_W,
  parameter int unsigned PROF_N  = dds_qmod_pkg::PROF_N,
  parameter int unsigned PH_W    = dds_qmod_pkg::PH_W,
  parameter int unsigned ADDR_W  = dds_qmod_pkg::ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_sen_i,
  input  logic                          cfg_sdi_i,
  input  logic [$clog2(PROF_N)-1:0]     prof_sel_i,
  input  logic signed [DATA_W-1:0]      i_data_i,
  input  logic signed [DATA_W-1:0]      q_data_i,
  output logic signed [DATA_W-1:0]      dac_o
);
  mode_e                        mode;
  logic [SCALE_W-1:0]           scale;
  logic [PROF_N-1:0][FTW_W-1:0] ftw;
  logic signed [DATA_W-1:0]     lo_cos, lo_sin, mix;

  dds_cfg_port #(
    .FTW_W(FTW_W), .SCALE_W(SCALE_W), .PROF_N(PROF_N), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .sen_i(cfg_sen_i), .sdi_i(cfg_sdi_i),
    .mode_o(mode), .scale_o(scale), .ftw_o(ftw)
  );

  dds_nco #(
    .FTW_W(FTW_W), .PROF_N(PROF_N), .PH_W(PH_W), .DATA_W(DATA_W)
  ) u_nco (
    .clk_i, .rst_ni,
    .ftw_i(ftw), .sel_i(prof_sel_i),
    .cos_o(lo_cos), .sin_o(lo_sin)
  );

  dds_mixer #(.DATA_W(DATA_W)) u_mix (
    .clk_i, .rst_ni,
    .mode_i(mode), .i_i(i_data_i), .q_i(q_data_i),
    .cos_i(lo_cos), .sin_i(lo_sin), .mix_o(mix)
  );

  dds_scaler #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_scl (
    .clk_i, .rst_ni,
    .mix_i(mix), .scale_i(scale), .y_o(dac_o)
  );

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 1'b1;
  end

  // R7: pass-through delivers I two clocks later, whatever Q does
  p_pass_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && mode == MODE_PASS) |=> (mix == $past(i_data_i, 2)));
endmodule

// File: tb/dds_qmod_tb_top.sv
module dds_qmod_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam time CLK_PERIOD = 10ns;
  localparam int  LAT = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_sen_i = 1'b0;
  logic              cfg_sdi_i = 1'b0;
  logic [1:0]        prof_sel_i = 2'd0;
  logic signed [13:0] i_data_i = '0;
  logic signed [13:0] q_data_i = '0;
  logic signed [13:0] dac_o;

  dds_qmod dut_i (
    .clk_i, .rst_ni, .cfg_sen_i, .cfg_sdi_i, .prof_sel_i,
    .i_data_i, .q_data_i, .dac_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // reference state, taken from the requirements
  logic [31:0] m_acc;
  logic [31:0] m_ftw [4] = '{default: 32'd0};
  int          m_mode  = 0;
  int          m_scale = 128;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) m_acc <= '0;
    else         m_acc <= m_acc + m_ftw[prof_sel_i];

  typedef struct {
    int    exp;
    int    stamp;
    string tag;
  } item_t;
  item_t sb_q[$];
  item_t mon_it;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: dac_o=%0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int sat14(input longint v);
    if (v > 8191)  return 8191;
    if (v < -8192) return -8192;
    return int'(v);
  endfunction

  function automatic int lo_val(input int a);
    longint x, m;
    x = longint'(a % 512);
    m = (x * (512 - x) * 8191) / 65536;
    return (a >= 512) ? -int'(m) : int'(m);
  endfunction

  function automatic int model_out(input int iv, input int qv, input logic [31:0] acc);
    int a, c, s, mix;
    a = int'(acc[31:22]);
    s = lo_val(a);
    c = lo_val((a + 256) % 1024);
    case (m_mode)
      1:       mix = c;
      2:       mix = iv;
      default: mix = sat14((longint'(iv) * c + longint'(qv) * s) >>> 13);
    endcase
    return sat14((longint'(mix) * m_scale) >>> 7);
  endfunction

  // monitor: compare each expected item once its latency has elapsed
  always @(negedge clk_i) begin
    if (sb_q.size() > 0 && sb_q[0].stamp + LAT == cyc) begin
      mon_it = sb_q.pop_front();
      check(mon_it.tag, int'(dac_o), mon_it.exp);
    end
  end

  task automatic cfg_write(input logic [7:0] addr, input logic [31:0] data, input int nbits);
    logic [39:0] frame;
    frame = {addr, data};
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk_i);
      cfg_sen_i = 1'b1;
      cfg_sdi_i = (b < 40) ? frame[39 - b] : 1'b0;
    end
    @(negedge clk_i);
    cfg_sen_i = 1'b0;
    cfg_sdi_i = 1'b0;
    @(posedge clk_i);
    #1;
    if (nbits == 40) begin
      if (addr == 8'h00) m_mode = int'(data[1:0]);
      else if (addr == 8'h01) m_scale = int'(data[7:0]);
      else if (addr >= 8'h10 && addr <= 8'h13) m_ftw[addr - 8'h10] = data;
    end
  endtask

  // driver: pat 0 random, 1 full positive, 2 full negative, 3 random with profile hopping
  task automatic drive(input string tag, input int n, input int pat);
    int iv, qv;
    item_t it;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      case (pat)
        1:       begin iv = 8191;  qv = 8191;  end
        2:       begin iv = -8192; qv = -8192; end
        default: begin
          iv = int'($urandom_range(0, 16383)) - 8192;
          qv = int'($urandom_range(0, 16383)) - 8192;
        end
      endcase
      if (pat == 3 && (k % 5) == 0) prof_sel_i = prof_sel_i + 2'd1;
      i_data_i = 14'(iv);
      q_data_i = 14'(qv);
      it.exp   = model_out(iv, qv, m_acc);
      it.stamp = cyc;
      it.tag   = tag;
      sb_q.push_back(it);
    end
    repeat (LAT + 1) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset output", int'(dac_o), 0);

    // R1: defaults are quadrature mode, unity gain, zero tuning words
    drive("R1", 20, 0);

    // R2: serial load of tuning word 0, then quadrature run (R5)
    cfg_write(8'h10, 32'h0123_4567, 40);
    drive("R2", 30, 0);
    drive("R5", 60, 0);

    // R4: profile 2 in steady use
    cfg_write(8'h11, 32'h3000_0000, 40);
    cfg_write(8'h12, 32'h0800_0001, 40);
    cfg_write(8'h13, 32'hF000_0000, 40);
    prof_sel_i = 2'd2;
    drive("R4", 40, 0);

    // R10: profile pins hop during the run
    drive("R10", 80, 3);

    // R9: full-scale inputs and maximum gain clip
    prof_sel_i = 2'd0;
    cfg_write(8'h01, 32'h0000_00FF, 40);
    drive("R9", 30, 1);
    drive("R9", 30, 2);

    // R6: tone mode ignores I and Q
    cfg_write(8'h01, 32'h0000_0080, 40);
    cfg_write(8'h00, 32'h0000_0001, 40);
    drive("R6", 40, 0);
    drive("R6", 20, 1);

    // R7: pass-through ignores Q
    cfg_write(8'h00, 32'h0000_0002, 40);
    drive("R7", 40, 0);

    // R8: several gains
    cfg_write(8'h01, 32'h0000_0040, 40);
    drive("R8", 30, 0);
    cfg_write(8'h01, 32'h0000_0000, 40);
    drive("R8", 10, 0);
    cfg_write(8'h01, 32'h0000_00C8, 40);
    drive("R8", 30, 0);

    // R3: short, long and unknown-address frames leave pass-through and gain 200
    cfg_write(8'h00, 32'h0000_0001, 39);
    drive("R3", 20, 0);
    cfg_write(8'h00, 32'h0000_0001, 41);
    drive("R3", 20, 0);
    cfg_write(8'h07, 32'h0000_0001, 40);
    cfg_write(8'h02, 32'h0000_0010, 40);
    drive("R3", 20, 0);

    // R5: unused mode code 3 behaves as quadrature
    cfg_write(8'h00, 32'h0000_0003, 40);
    prof_sel_i = 2'd1;
    drive("R5", 40, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule